// File: doc/BRIEF.md
# Display Memory Write Address Sequencer

This block sits between a host command decoder and a display memory laid out as 102 columns by 9 banks of one byte each. The host sets a column pointer and a bank pointer, sets a wrap limit for each of them, and selects three options: the walk order (across columns first or down banks first), column mirroring, and bit reversal inside each byte. Each data byte the host sends is written at the current location. The pointers then move on, so a stream of bytes fills a rectangular window without further commands.

A command and a data byte arrive on separate valid-qualified inputs. For every accepted byte the block issues one write strobe, together with the physical column, the bank and the byte as it should be stored. A memory array behind it can take these signals directly as its write port.

Top module: `dram_wr_seq`

## Requirements
- R1: After a synchronous active-low reset, the column and bank pointers are 0, the column limit is 101, the bank limit is 8, and all three option bits are 0. The write strobe is low.
- R2: A byte accepted in cycle n raises `ram_we` for exactly cycle n+1 with the address from the pointers of that cycle. The pointers advance at the clock edge that ends cycle n+1, so bytes may be sent back to back.
- R3: With the walk-order bit at 0, each write increments the column pointer. A write at a column that is at or past the column limit sets the column to 0 and increments the bank pointer.
- R4: With the walk-order bit at 1, each write increments the bank pointer. A write at a bank that is at or past the bank limit sets the bank to 0 and increments the column pointer.
- R5: A write at the location where both pointers are at their limits sends both pointers to 0, in either walk order.
- R6: With the mirror bit at 0, `ram_col` equals the column pointer. With the mirror bit at 1, it equals 101 minus the column pointer. Pointer movement is the same in both cases.
- R7: With the bit-order bit at 0, `ram_data` equals the accepted byte. With the bit-order bit at 1, bit i of `ram_data` is bit 7-i of the accepted byte.
- R8: Loading the column or bank pointer with a value above the present limit of that axis loads the limit instead.
- R9: Loading a limit above 101 (column) or 8 (bank) stores 101 or 8.
- R10: A byte presented in the same cycle as a command is dropped: no strobe follows it and the pointers do not move for it.
- R11: Command codes on `cmd_op`: 0 loads the column pointer, 1 loads the bank pointer, 2 loads the column limit, 3 loads the bank limit, 4 loads the options from `cmd_arg`. In that argument, bit 0 is the walk order, bit 1 is mirror and bit 2 is bit order. Codes 5 to 7 do nothing. A command in the same cycle as a strobe overrides the advance of the pointer it loads. The advance in that cycle uses the options and limits held before the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Command code (R11) |
| cmd_arg | input | 8 | Command argument |
| dat_valid | input | 1 | Data byte present this cycle |
| dat_byte | input | 8 | Data byte |
| ram_we | output | 1 | Memory write strobe |
| ram_col | output | 7 | Physical column of the write |
| ram_bank | output | 4 | Bank of the write |
| ram_data | output | 8 | Byte to store, after optional reversal |

## Verification
A command takes effect at the first clock edge after it is presented. A byte's strobe, address and stored value appear in the next cycle, and the pointer move caused by that byte becomes visible at the strobe of the following byte. The bench drives inputs on the falling edge and reads the write port one falling edge after each byte. It then drives the next item in that same half cycle, so each check falls exactly in the strobe cycle and commands can land in a strobe cycle on purpose. Dropped bytes are checked by confirming that the strobe stays low in the cycle where it would otherwise appear, and that the next accepted byte lands at the unmoved location.

// File: rtl/dram_seq_pkg.sv
// Shared constants and types for the display memory write sequencer.
// Assumes an 8-bit command argument and a 3-bit command code.
package dram_seq_pkg;
    localparam int unsigned DEF_COLS  = 102;
    localparam int unsigned DEF_BANKS = 9;
    localparam int unsigned DEF_ARG_W = 8;
    localparam int unsigned DEF_DAT_W = 8;

    typedef enum logic [2:0] {
        OP_SET_X    = 3'd0,
        OP_SET_Y    = 3'd1,
        OP_SET_XLIM = 3'd2,
        OP_SET_YLIM = 3'd3,
        OP_SET_MODE = 3'd4
    } seq_op_e;

    typedef struct packed {
        logic d0;    // reverse bit order when set
        logic mx;    // mirror physical column when set
        logic vert;  // walk down banks first when set
    } seq_mode_t;
endpackage

// File: rtl/dram_ptr_axis.sv
// One address axis: a pointer and its wrap limit.
// The limit load clamps to MAX_VAL; a pointer load clamps to the present limit.
// A step wraps to 0 when the pointer is at or past the limit, otherwise adds 1.
// Assumes PTR_W <= ARG_W and that loads and steps are mutually exclusive
// in priority (a pointer load wins over a step).
module dram_ptr_axis #(
    parameter int unsigned MAX_VAL = 101,
    parameter int unsigned ARG_W   = 8,
    localparam int unsigned PTR_W  = $clog2(MAX_VAL + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lim_wr,
    input  logic             ptr_wr,
    input  logic [ARG_W-1:0] load_val,
    input  logic             step,
    output logic [PTR_W-1:0] ptr,
    output logic [PTR_W-1:0] lim,
    output logic             at_lim
);
    localparam logic [PTR_W-1:0] MAX_P = PTR_W'(MAX_VAL);

    logic [PTR_W-1:0] lim_next_val;
    logic [PTR_W-1:0] ptr_load_val;

    // Clamp candidate values for the limit and the pointer loads.
    always_comb begin
        lim_next_val = (32'(load_val) > 32'(MAX_VAL)) ? MAX_P : load_val[PTR_W-1:0];
        ptr_load_val = (32'(load_val) > 32'(lim)) ? lim : load_val[PTR_W-1:0];
    end

    assign at_lim = (ptr >= lim);

    // Limit register: reset to the axis maximum, reloaded by command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lim <= MAX_P;
        end else if (lim_wr) begin
            lim <= lim_next_val;
        end
    end

    // Pointer register: load has priority over the auto advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (ptr_wr) begin
            ptr <= ptr_load_val;
        end else if (step) begin
            ptr <= at_lim ? '0 : ptr + 1'b1;
        end
    end
endmodule

// File: rtl/dram_col_map.sv
// Logical to physical column mapping.
// Normal: physical equals logical; mirrored: physical is (NUM_COLS-1) - logical.
// Assumes the logical column never exceeds NUM_COLS-1 (guaranteed by the limits).
module dram_col_map #(
    parameter int unsigned NUM_COLS = 102,
    localparam int unsigned COL_W   = $clog2(NUM_COLS)
) (
    input  logic             mirror,
    input  logic [COL_W-1:0] log_col,
    output logic [COL_W-1:0] phys_col
);
    localparam logic [COL_W-1:0] LAST_COL = COL_W'(NUM_COLS - 1);

    // Select straight or reflected column.
    always_comb begin
        phys_col = mirror ? (LAST_COL - log_col) : log_col;
    end
endmodule

// File: rtl/dram_byte_order.sv
// Optional bit reversal of a data word before it is stored.
// Assumes nothing about the word width beyond DW >= 1.
module dram_byte_order #(
    parameter int unsigned DW = 8
) (
    input  logic          rev_en,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);
    logic [DW-1:0] rev;

    for (genvar i = 0; i < DW; i++) begin : g_rev
        assign rev[i] = din[DW-1-i];
    end

    // Pass straight through or reversed.
    always_comb begin
        dout = rev_en ? rev : din;
    end
endmodule

// File: rtl/dram_wr_seq.sv
// Display memory write address sequencer (top).
// Decodes host commands into pointer, limit and option loads, accepts data
// bytes, issues one registered write strobe per byte and advances the column
// and bank pointers at that strobe according to the selected walk order.
// Assumes the command decoder presents at most one command per cycle; a byte
// presented together with a command is dropped.
module dram_wr_seq
    import dram_seq_pkg::*;
#(
    parameter int unsigned NUM_COLS  = DEF_COLS,
    parameter int unsigned NUM_BANKS = DEF_BANKS,
    parameter int unsigned ARG_W     = DEF_ARG_W,
    parameter int unsigned DAT_W     = DEF_DAT_W,
    localparam int unsigned COL_W    = $clog2(NUM_COLS),
    localparam int unsigned BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [ARG_W-1:0]  cmd_arg,
    input  logic              dat_valid,
    input  logic [DAT_W-1:0]  dat_byte,
    output logic              ram_we,
    output logic [COL_W-1:0]  ram_col,
    output logic [BANK_W-1:0] ram_bank,
    output logic [DAT_W-1:0]  ram_data
);
    seq_op_e          op;
    logic             x_wr, y_wr, xl_wr, yl_wr, mode_wr;
    logic             dat_take;
    logic             we_q;
    logic [DAT_W-1:0] data_q;
    seq_mode_t        mode_q;
    logic             step_x, step_y;
    logic             x_at_lim, y_at_lim;
    logic [COL_W-1:0]  x_ptr, x_lim;
    logic [BANK_W-1:0] y_ptr, y_lim;

    assign op = seq_op_e'(cmd_op);

    // Command decode: one load enable per command code.
    always_comb begin
        x_wr    = cmd_valid && (op == OP_SET_X);
        y_wr    = cmd_valid && (op == OP_SET_Y);
        xl_wr   = cmd_valid && (op == OP_SET_XLIM);
        yl_wr   = cmd_valid && (op == OP_SET_YLIM);
        mode_wr = cmd_valid && (op == OP_SET_MODE);
    end

    assign dat_take = dat_valid && !cmd_valid;

    // Capture the byte and schedule its strobe for the next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_q   <= 1'b0;
            data_q <= '0;
        end else begin
            we_q <= dat_take;
            if (dat_take) begin
                data_q <= dat_byte;
            end
        end
    end

    // Option register: walk order, mirror, bit order.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (mode_wr) begin
            mode_q <= seq_mode_t'(cmd_arg[2:0]);
        end
    end

    // Advance rules: the fast axis steps every strobe, the slow axis on wrap.
    always_comb begin
        step_x = we_q && (mode_q.vert ? y_at_lim : 1'b1);
        step_y = we_q && (mode_q.vert ? 1'b1 : x_at_lim);
    end

    dram_ptr_axis #(
        .MAX_VAL (NUM_COLS - 1),
        .ARG_W   (ARG_W)
    ) u_x_axis (
        .clk      (clk),
        .rst_n    (rst_n),
        .lim_wr   (xl_wr),
        .ptr_wr   (x_wr),
        .load_val (cmd_arg),
        .step     (step_x),
        .ptr      (x_ptr),
        .lim      (x_lim),
        .at_lim   (x_at_lim)
    );

    dram_ptr_axis #(
        .MAX_VAL (NUM_BANKS - 1),
        .ARG_W   (ARG_W)
    ) u_y_axis (
        .clk      (clk),
        .rst_n    (rst_n),
        .lim_wr   (yl_wr),
        .ptr_wr   (y_wr),
        .load_val (cmd_arg),
        .step     (step_y),
        .ptr      (y_ptr),
        .lim      (y_lim),
        .at_lim   (y_at_lim)
    );

    dram_col_map #(
        .NUM_COLS (NUM_COLS)
    ) u_col_map (
        .mirror   (mode_q.mx),
        .log_col  (x_ptr),
        .phys_col (ram_col)
    );

    dram_byte_order #(
        .DW (DAT_W)
    ) u_byte_order (
        .rev_en (mode_q.d0),
        .din    (data_q),
        .dout   (ram_data)
    );

    assign ram_we   = we_q;
    assign ram_bank = y_ptr;
endmodule

// File: rtl/dram_wr_seq_chk.sv
// Property checker for the write sequencer, attached by bind.
// Observes the host ports, the write port and the pointer/limit state.
module dram_wr_seq_chk #(
    parameter int unsigned NUM_COLS  = 102,
    parameter int unsigned NUM_BANKS = 9,
    localparam int unsigned COL_W    = $clog2(NUM_COLS),
    localparam int unsigned BANK_W   = $clog2(NUM_BANKS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [2:0]        cmd_op,
    input logic              dat_valid,
    input logic              ram_we,
    input logic [COL_W-1:0]  ram_col,
    input logic [BANK_W-1:0] ram_bank,
    input logic [COL_W-1:0]  x_ptr,
    input logic [BANK_W-1:0] y_ptr,
    input logic [COL_W-1:0]  x_lim,
    input logic [BANK_W-1:0] y_lim,
    input logic              mode_v
);
    localparam logic [COL_W-1:0]  LAST_COL  = COL_W'(NUM_COLS - 1);
    localparam logic [BANK_W-1:0] LAST_BANK = BANK_W'(NUM_BANKS - 1);

    assert_strobe_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_valid && !cmd_valid) |=> ram_we);

    assert_no_stray_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !dat_valid |=> !ram_we);

    assert_cmd_drops_byte_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && dat_valid) |=> !ram_we);

    assert_horiz_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && !cmd_valid && !mode_v && (x_ptr < x_lim))
        |=> (x_ptr == COL_W'($past(x_ptr) + 1'b1)) && (y_ptr == $past(y_ptr)));

    assert_vert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && !cmd_valid && mode_v && (y_ptr < y_lim))
        |=> (y_ptr == BANK_W'($past(y_ptr) + 1'b1)) && (x_ptr == $past(x_ptr)));

    assert_corner_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && !cmd_valid && (x_ptr >= x_lim) && (y_ptr >= y_lim))
        |=> (x_ptr == '0) && (y_ptr == '0));

    assert_addr_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> ((ram_col <= LAST_COL) && (ram_bank <= LAST_BANK)));

    assert_x_load_clamp_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd_op == 3'd0)) |=> (x_ptr <= x_lim));

    assert_y_load_clamp_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd_op == 3'd1)) |=> (y_ptr <= y_lim));

    assert_limit_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (x_lim <= LAST_COL) && (y_lim <= LAST_BANK));
endmodule

bind dram_wr_seq dram_wr_seq_chk #(
    .NUM_COLS  (NUM_COLS),
    .NUM_BANKS (NUM_BANKS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .dat_valid (dat_valid),
    .ram_we    (ram_we),
    .ram_col   (ram_col),
    .ram_bank  (ram_bank),
    .x_ptr     (x_ptr),
    .y_ptr     (y_ptr),
    .x_lim     (x_lim),
    .y_lim     (y_lim),
    .mode_v    (mode_q.vert)
);

// File: tb/dram_wr_seq_test.sv
// Self-checking bench: a vector table of commands and writes, then directed cases.
module dram_wr_seq_test;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       cmd_valid;
    logic [2:0] cmd_op;
    logic [7:0] cmd_arg;
    logic       dat_valid;
    logic [7:0] dat_byte;
    logic       ram_we;
    logic [6:0] ram_col;
    logic [3:0] ram_bank;
    logic [7:0] ram_data;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    dram_wr_seq uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_arg   (cmd_arg),
        .dat_valid (dat_valid),
        .dat_byte  (dat_byte),
        .ram_we    (ram_we),
        .ram_col   (ram_col),
        .ram_bank  (ram_bank),
        .ram_data  (ram_data)
    );

    // Vector fields: {is_data, op, arg/byte, exp_col, exp_bank, exp_data, req}
    localparam int NV = 34;
    localparam logic [34:0] VEC [NV] = '{
        {1'b0, 3'd2, 8'd2,   7'd0,   4'd0, 8'h00, 4'd11}, // col limit 2
        {1'b0, 3'd3, 8'd1,   7'd0,   4'd0, 8'h00, 4'd11}, // bank limit 1
        {1'b1, 3'd0, 8'hA5,  7'd0,   4'd0, 8'hA5, 4'd3},  // R3
        {1'b1, 3'd0, 8'h3C,  7'd1,   4'd0, 8'h3C, 4'd3},
        {1'b1, 3'd0, 8'h01,  7'd2,   4'd0, 8'h01, 4'd3},
        {1'b1, 3'd0, 8'h02,  7'd0,   4'd1, 8'h02, 4'd3},  // R3 bank step
        {1'b1, 3'd0, 8'h03,  7'd1,   4'd1, 8'h03, 4'd3},
        {1'b1, 3'd0, 8'h04,  7'd2,   4'd1, 8'h04, 4'd5},
        {1'b1, 3'd0, 8'h05,  7'd0,   4'd0, 8'h05, 4'd5},  // R5 wrap
        {1'b0, 3'd4, 8'd1,   7'd0,   4'd0, 8'h00, 4'd11}, // vertical
        {1'b0, 3'd0, 8'd0,   7'd0,   4'd0, 8'h00, 4'd11},
        {1'b0, 3'd1, 8'd0,   7'd0,   4'd0, 8'h00, 4'd11},
        {1'b1, 3'd0, 8'h10,  7'd0,   4'd0, 8'h10, 4'd4},  // R4
        {1'b1, 3'd0, 8'h11,  7'd0,   4'd1, 8'h11, 4'd4},
        {1'b1, 3'd0, 8'h12,  7'd1,   4'd0, 8'h12, 4'd4},
        {1'b1, 3'd0, 8'h13,  7'd1,   4'd1, 8'h13, 4'd4},
        {1'b1, 3'd0, 8'h14,  7'd2,   4'd0, 8'h14, 4'd4},
        {1'b1, 3'd0, 8'h15,  7'd2,   4'd1, 8'h15, 4'd5},
        {1'b1, 3'd0, 8'h16,  7'd0,   4'd0, 8'h16, 4'd5},
        {1'b0, 3'd4, 8'd6,   7'd0,   4'd0, 8'h00, 4'd11}, // mirror + reverse
        {1'b0, 3'd2, 8'd200, 7'd0,   4'd0, 8'h00, 4'd9},  // R9 clamp to 101
        {1'b0, 3'd3, 8'd8,   7'd0,   4'd0, 8'h00, 4'd11},
        {1'b0, 3'd1, 8'd0,   7'd0,   4'd0, 8'h00, 4'd11},
        {1'b1, 3'd0, 8'h01,  7'd101, 4'd0, 8'h80, 4'd7},  // R7 R6
        {1'b1, 3'd0, 8'hC2,  7'd100, 4'd0, 8'h43, 4'd6},
        {1'b0, 3'd0, 8'd150, 7'd0,   4'd0, 8'h00, 4'd8},  // R8 clamp
        {1'b1, 3'd0, 8'h0F,  7'd0,   4'd0, 8'hF0, 4'd8},
        {1'b1, 3'd0, 8'h00,  7'd101, 4'd1, 8'h00, 4'd6},
        {1'b0, 3'd1, 8'd12,  7'd0,   4'd0, 8'h00, 4'd8},
        {1'b0, 3'd0, 8'd101, 7'd0,   4'd0, 8'h00, 4'd11},
        {1'b1, 3'd0, 8'h08,  7'd0,   4'd8, 8'h10, 4'd8},
        {1'b1, 3'd0, 8'h09,  7'd101, 4'd0, 8'h90, 4'd5},
        {1'b0, 3'd3, 8'd3,   7'd0,   4'd0, 8'h00, 4'd11},
        {1'b0, 3'd1, 8'd7,   7'd0,   4'd0, 8'h00, 4'd8}
    };

    task automatic chk(input string tag, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic do_cmd(input logic [2:0] op, input logic [7:0] arg);
        cmd_valid = 1'b1; cmd_op = op; cmd_arg = arg;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    // Send a byte at a falling edge; its strobe is read one falling edge later.
    task automatic wr_chk(input logic [7:0] b, input int col, input int bank,
                          input int data, input string tag);
        dat_valid = 1'b1; dat_byte = b;
        @(negedge clk);
        dat_valid = 1'b0;
        chk(tag, int'(ram_we),   1,    "ram_we");
        chk(tag, int'(ram_col),  col,  "ram_col");
        chk(tag, int'(ram_bank), bank, "ram_bank");
        chk(tag, int'(ram_data), data, "ram_data");
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        cmd_valid = 1'b0; cmd_op = '0; cmd_arg = '0;
        dat_valid = 1'b0; dat_byte = '0;
        @(negedge clk);
        do_reset();
        chk("R1", int'(ram_we), 0, "ram_we after reset");

        // Table walk: commands take effect at the next edge, writes checked in their strobe cycle.
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][34]) begin
                wr_chk(VEC[i][30:23], int'(VEC[i][22:16]), int'(VEC[i][15:12]),
                       int'(VEC[i][11:4]), $sformatf("R%0d", VEC[i][3:0]));
            end else begin
                do_cmd(VEC[i][33:31], VEC[i][30:23]);
            end
        end
        // Bank 7 clamped to limit 3, column pointer now 1, mirrored and reversed (R8)
        wr_chk(8'h20, 100, 3, 8'h04, "R8");
        do_cmd(3'd4, 8'd0);
        wr_chk(8'h81, 2, 3, 8'h81, "R7");
        @(negedge clk);
        chk("R2", int'(ram_we), 0, "single strobe per byte");

        // R1: defaults after reset (limits 101/8, horizontal, no mirror, no reversal)
        do_reset();
        chk("R1", int'(ram_we), 0, "ram_we after reset");
        wr_chk(8'h5A, 0, 0, 8'h5A, "R1");
        wr_chk(8'hAA, 1, 0, 8'hAA, "R2");  // back to back
        do_cmd(3'd0, 8'd101);
        wr_chk(8'h33, 101, 0, 8'h33, "R1");
        wr_chk(8'h34, 0, 1, 8'h34, "R3");

        // R10: byte together with a command is dropped
        do_cmd(3'd0, 8'd5);
        cmd_valid = 1'b1; cmd_op = 3'd0; cmd_arg = 8'd7; dat_valid = 1'b1; dat_byte = 8'hEE;
        @(negedge clk);
        cmd_valid = 1'b0; dat_valid = 1'b0;
        @(negedge clk);
        chk("R10", int'(ram_we), 0, "strobe after dropped byte");
        wr_chk(8'h77, 7, 1, 8'h77, "R10");

        // R11: unused code 5 changes nothing
        do_cmd(3'd5, 8'd0);
        wr_chk(8'h78, 8, 1, 8'h78, "R11");

        // R4: vertical walk at full bank limit advances the column
        do_cmd(3'd4, 8'd1);
        do_cmd(3'd0, 8'd0);
        do_cmd(3'd1, 8'd8);
        wr_chk(8'h61, 0, 8, 8'h61, "R4");
        wr_chk(8'h62, 1, 0, 8'h62, "R4");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule